// File: doc/BRIEF.md
# Time-Sliced H-Bridge Motor PWM Controller

This block drives two DC motors, each through its own full H-bridge. For each motor it turns an 8-bit speed-and-direction command into four gate enables: the high and low switch on terminal A, and the high and low switch on terminal B. Pulses are timed against an external square-wave phase reference. A slot-select input picks which half of that reference the pulses may use, so that several boards sharing one supply draw current at different times.

The two motors take turns on successive phase cycles. In its turn, a motor gets one pulse of up to 127 clocks inside a 130-clock half period. The pulse is framed by single all-off clocks, which prevent shoot-through. Between pulses the winding is shorted through both low switches, so the motor brakes and current sensing stays active. An active-low overcurrent input per motor stops the drive at once. The phase reference, slot select and fault inputs are asynchronous and are synchronized inside the block.

Top module: `hbridge_slot_pwm`

## Requirements
- R1: While reset is low, and after reset until the first phase edge has been seen, every motor's gate nibble is the brake pattern 4'b1010. Gate nibble bits are: bit0 high switch on A, bit1 low switch on A, bit2 high switch on B, bit3 low switch on B.
- R2: In a command, bit 7 is the direction (0 forward) and bits 6:0 are the magnitude. A forward pulse shows 4'b1001 (high A, low B) for exactly magnitude clocks.
- R3: A reverse command (bit 7 = 1) shows 4'b0110 (high B, low A) for exactly magnitude clocks.
- R4: Every pulse is preceded by exactly one 4'b0000 clock that follows brake, and is followed by exactly one 4'b0000 clock before brake returns.
- R5: The high and low switch of the same terminal are never enabled in the same clock.
- R6: With slot select 0, a motor's pulse starts while the phase reference is high, three clocks after its rising edge. With slot select 1, it starts while the phase reference is low, three clocks after its falling edge.
- R7: Motors take turns on successive phase cycles, starting with motor 0 after reset. Consecutive pulses of motor 0 and motor 1 start exactly one phase period apart.
- R8: A command is latched at the start of its motor's slot. A change during a pulse does not alter that pulse and takes effect at the next slot.
- R9: A magnitude of zero gives no pulse and no all-off clocks; the nibble stays at brake.
- R10: While a motor's fault input is low, no new pulse starts. A pulse in progress ends within three clocks and passes through one all-off clock into brake. Pulses resume at the first slot after the fault input returns high.
- R11: The largest magnitude, 127, gives a 127-clock pulse, so the whole off-pulse-off frame of 129 clocks fits in a 130-clock half period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock (16.384 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_i | input | 1 | Asynchronous square-wave phase reference |
| slot_i | input | 1 | Half-period select: 0 high half, 1 low half |
| fault_ni | input | 2 | Per-motor overcurrent flag, active low, asynchronous |
| cmd_i | input | 16 | Commands; motor k at bits 8k+7:8k, bit 7 direction, bits 6:0 magnitude |
| gate_o | output | 8 | Gate enables; motor k at bits 4k+3:4k, nibble layout as in R1 |

## Verification
The hardest case to reach is a fault that arrives in the middle of a pulse. Through the synchronizer, the fault has to land while the counter is still running, and the pulse must then still pass through its trailing all-off clock. The bench sets up a long pulse and waits for its leading all-off clock. It counts drive clocks at the falling edge and pulls the fault input low at a chosen count, which places the cut at a known point in the pulse. It then holds the fault low across whole slots, which shows that the motor stays in brake, and releases it to show that the full width returns.

// File: rtl/hbridge_pwm_pkg.sv
`timescale 1ns/1ps
package hbridge_pwm_pkg;
  // gate nibble bit positions
  localparam int GB_HI_A = 0;
  localparam int GB_LO_A = 1;
  localparam int GB_HI_B = 2;
  localparam int GB_LO_B = 3;

  localparam logic [3:0] GATE_OFF   = 4'b0000;
  localparam logic [3:0] GATE_BRAKE = 4'b1010;
  localparam logic [3:0] GATE_FWD   = 4'b1001;
  localparam logic [3:0] GATE_REV   = 4'b0110;

  typedef enum logic [1:0] {
    ST_BRAKE,
    ST_LEAD,
    ST_DRIVE,
    ST_TRAIL
  } ch_state_e;
endpackage

// File: rtl/pwm_sync2.sv
`timescale 1ns/1ps
module pwm_sync2 #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pwm_slot_timer.sv
`timescale 1ns/1ps
module pwm_slot_timer #(
  parameter  int NUM_MOT = 2,
  localparam int TW      = (NUM_MOT > 1) ? $clog2(NUM_MOT) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               phase_s_i,
  input  logic               slot_s_i,
  output logic [NUM_MOT-1:0] start_o
);
  logic          ph_d_q;
  logic [TW-1:0] turn_q, turn_nx, owner;
  logic          rise, fall, ev;

  assign rise    = phase_s_i & ~ph_d_q;
  assign fall    = ~phase_s_i & ph_d_q;
  assign turn_nx = (turn_q == TW'(NUM_MOT - 1)) ? '0 : turn_q + 1'b1;
  assign ev      = slot_s_i ? fall : rise;
  // a rising edge opens a new cycle, so the high-half slot belongs to the next owner
  assign owner   = slot_s_i ? turn_q : turn_nx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_d_q <= 1'b0;
      turn_q <= TW'(NUM_MOT - 1);
    end else begin
      ph_d_q <= phase_s_i;
      if (rise) turn_q <= turn_nx;
    end
  end

  for (genvar k = 0; k < NUM_MOT; k++) begin : g_start
    assign start_o[k] = ev && (owner == TW'(k));
  end
endmodule

// File: rtl/hb_channel.sv
`timescale 1ns/1ps
module hb_channel
  import hbridge_pwm_pkg::*;
#(
  parameter  int CMD_W = 8,
  localparam int MAG_W = CMD_W - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             fault_ok_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic [3:0]       gate_o
);
  ch_state_e        state_q, state_d;
  logic [MAG_W-1:0] cnt_q, cnt_d;
  logic             rev_q, rev_d;
  logic [MAG_W-1:0] mag;

  assign mag = cmd_i[MAG_W-1:0];

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rev_d   = rev_q;
    unique case (state_q)
      ST_BRAKE: if (start_i && fault_ok_i && (mag != '0)) begin
        state_d = ST_LEAD;
        cnt_d   = mag;
        rev_d   = cmd_i[CMD_W-1];
      end
      ST_LEAD:  state_d = fault_ok_i ? ST_DRIVE : ST_BRAKE;
      ST_DRIVE: begin
        cnt_d = cnt_q - 1'b1;
        if (!fault_ok_i || (cnt_q == MAG_W'(1))) state_d = ST_TRAIL;
      end
      ST_TRAIL: state_d = ST_BRAKE;
      default:  state_d = ST_BRAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_BRAKE;
      cnt_q   <= '0;
      rev_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rev_q   <= rev_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_BRAKE: gate_o = GATE_BRAKE;
      ST_DRIVE: gate_o = rev_q ? GATE_REV : GATE_FWD;
      default:  gate_o = GATE_OFF;
    endcase
  end

  // R5: no shoot-through on either terminal
  p_no_shoot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((gate_o[GB_HI_A] && gate_o[GB_LO_A]) || (gate_o[GB_HI_B] && gate_o[GB_LO_B])));

  // R4: leaving brake goes through all-off
  p_dead_lead_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o == GATE_BRAKE) |=> (gate_o == GATE_BRAKE || gate_o == GATE_OFF));

  // R4: leaving drive goes through all-off
  p_dead_trail_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o == GATE_FWD || gate_o == GATE_REV) |=> (gate_o == $past(gate_o) || gate_o == GATE_OFF));

  // R10: no drive in the cycle after a fault is seen
  p_fault_cut_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_ok_i |=> (gate_o != GATE_FWD && gate_o != GATE_REV));

  // R9: zero magnitude keeps brake
  p_zero_mag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mag == '0 && gate_o == GATE_BRAKE) |=> (gate_o == GATE_BRAKE));
endmodule

// File: rtl/hbridge_slot_pwm.sv
`timescale 1ns/1ps
module hbridge_slot_pwm #(
  parameter  int NUM_MOT = 2,
  parameter  int CMD_W   = 8,
  localparam int SYN_W   = NUM_MOT + 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     phase_i,
  input  logic                     slot_i,
  input  logic [NUM_MOT-1:0]       fault_ni,
  input  logic [NUM_MOT*CMD_W-1:0] cmd_i,
  output logic [NUM_MOT*4-1:0]     gate_o
);
  logic [SYN_W-1:0]   syn_q;
  logic [NUM_MOT-1:0] start;

  pwm_sync2 #(.W(SYN_W)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({fault_ni, slot_i, phase_i}),
    .q_o    (syn_q)
  );

  pwm_slot_timer #(.NUM_MOT(NUM_MOT)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .phase_s_i (syn_q[0]),
    .slot_s_i  (syn_q[1]),
    .start_o   (start)
  );

  for (genvar k = 0; k < NUM_MOT; k++) begin : g_ch
    hb_channel #(.CMD_W(CMD_W)) i_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (start[k]),
      .fault_ok_i (syn_q[2+k]),
      .cmd_i      (cmd_i[k*CMD_W +: CMD_W]),
      .gate_o     (gate_o[k*4 +: 4])
    );
  end
endmodule

// File: tb/test_hbridge_slot_pwm.sv
`timescale 1ns/1ps
module test_hbridge_slot_pwm;
  localparam int CLK_NS = 61;
  localparam int HALF   = 130;
  localparam logic [3:0] BRK = 4'b1010;
  localparam logic [3:0] FWD = 4'b1001;
  localparam logic [3:0] REV = 4'b0110;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        phase_i;
  logic        slot_i = 1'b0;
  logic [1:0]  fault_ni = 2'b11;
  logic [15:0] cmd_i = '0;
  logic [7:0]  gate_o;
  bit          phase_run = 1'b0;
  int          cyc = 0;
  int          n_tests = 0;
  int          n_fail = 0;
  int          shoot = 0;
  bit          done = 1'b0;

  hbridge_slot_pwm i_hbridge_slot_pwm (
    .clk_i(clk), .rst_ni(rst_ni), .phase_i(phase_i), .slot_i(slot_i),
    .fault_ni(fault_ni), .cmd_i(cmd_i), .gate_o(gate_o)
  );

  always #(CLK_NS/2.0) clk = ~clk;

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  initial begin
    int c = 0;
    phase_i = 1'b0;
    forever begin
      @(negedge clk);
      if (phase_run) begin
        c++;
        if (c == HALF) begin
          c = 0;
          phase_i = ~phase_i;
        end
      end
    end
  end

  // R5 monitor
  initial forever begin
    @(negedge clk);
    for (int k = 0; k < 2; k++)
      if ((gate_o[4*k] && gate_o[4*k+1]) || (gate_o[4*k+2] && gate_o[4*k+3])) shoot++;
  end

  function automatic logic [3:0] gate(input int k);
    return gate_o[4*k +: 4];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(input int k, input int tmo, input int chg, input int flt_at,
                         output int w, output logic [3:0] pat, output bit lead_ok,
                         output bit trail_ok, output logic ph, output int t0);
    int n = 0;
    w = 0; pat = '0; lead_ok = 0; trail_ok = 0; ph = 0; t0 = -1;
    while (gate(k) != BRK) @(negedge clk);
    while (gate(k) == BRK && n < tmo) begin
      @(negedge clk);
      n++;
    end
    if (n >= tmo) return;
    t0 = cyc; ph = phase_i; lead_ok = (gate(k) == 4'b0000);
    if (chg >= 0) cmd_i[8*k +: 8] = 8'(chg);
    @(negedge clk);
    pat = gate(k);
    while (gate(k) == pat && pat != 4'b0000 && pat != BRK) begin
      w++;
      if (w == flt_at) fault_ni[k] = 1'b0;
      @(negedge clk);
    end
    trail_ok = (gate(k) == 4'b0000);
    @(negedge clk);
    trail_ok &= (gate(k) == BRK);
  endtask

  int w, t0, t1, t2;
  logic [3:0] pat;
  bit lo, to;
  logic ph;

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (4) @(negedge clk);
    chk(gate_o == 8'hAA, "R1 reset brake", gate_o, 8'hAA);
    rst_ni = 1'b1;
    repeat (20) @(negedge clk);
    chk(gate_o == 8'hAA, "R1 idle before phase", gate_o, 8'hAA);
  endtask

  task automatic t_forward();
    cmd_i[7:0] = 8'd40;
    phase_run = 1'b1;
    measure(0, 700, -1, -1, w, pat, lo, to, ph, t0);
    chk(w == 40, "R2 fwd width", w, 40);
    chk(pat == FWD, "R2 fwd pattern", pat, FWD);
    chk(lo && to, "R4 dead framing", {lo, to}, 3);
    chk(ph == 1'b1, "R6 slot0 high half", ph, 1);
  endtask

  task automatic t_reverse();
    cmd_i[7:0] = 8'h80 | 8'd25;
    measure(0, 700, -1, -1, w, pat, lo, to, ph, t0);
    chk(w == 25, "R3 rev width", w, 25);
    chk(pat == REV, "R3 rev pattern", pat, REV);
  endtask

  task automatic t_max();
    cmd_i[7:0] = 8'd127;
    measure(0, 700, -1, -1, w, pat, lo, to, ph, t0);
    chk(w == 127, "R11 max width", w, 127);
    chk(lo && to, "R11 max frame dead", {lo, to}, 3);
  endtask

  task automatic t_zero();
    cmd_i[7:0] = 8'd0;
    measure(0, 700, -1, -1, w, pat, lo, to, ph, t0);
    chk(t0 == -1, "R9 zero no gaps", t0, -1);
  endtask

  task automatic t_alternate();
    cmd_i[7:0]  = 8'd10;
    cmd_i[15:8] = 8'h80 | 8'd20;
    measure(0, 700, -1, -1, w, pat, lo, to, ph, t0);
    measure(1, 700, -1, -1, w, pat, lo, to, ph, t1);
    chk(w == 20 && pat == REV, "R7 motor1 pulse", w, 20);
    chk(t1 - t0 == 2*HALF, "R7 m0->m1 spacing", t1 - t0, 2*HALF);
    measure(0, 700, -1, -1, w, pat, lo, to, ph, t2);
    chk(t2 - t1 == 2*HALF, "R7 m1->m0 spacing", t2 - t1, 2*HALF);
  endtask

  task automatic t_slot();
    slot_i = 1'b1;
    repeat (600) @(negedge clk);
    measure(0, 700, -1, -1, w, pat, lo, to, ph, t0);
    chk(ph == 1'b0, "R6 slot1 low half", ph, 0);
    chk(w == 10, "R6 slot1 width", w, 10);
    slot_i = 1'b0;
    repeat (600) @(negedge clk);
  endtask

  task automatic t_latch();
    cmd_i[7:0] = 8'd50;
    measure(0, 700, -1, -1, w, pat, lo, to, ph, t0);
    measure(0, 700, 5, -1, w, pat, lo, to, ph, t0);
    chk(w == 50, "R8 mid-pulse change ignored", w, 50);
    measure(0, 700, -1, -1, w, pat, lo, to, ph, t0);
    chk(w == 5, "R8 new command next slot", w, 5);
  endtask

  task automatic t_fault();
    cmd_i[7:0] = 8'd120;
    measure(0, 700, -1, 10, w, pat, lo, to, ph, t0);
    chk(w >= 10 && w <= 13, "R10 cut width", w, 12);
    chk(to, "R10 cut trailing dead", to, 1);
    measure(0, 700, -1, -1, w, pat, lo, to, ph, t0);
    chk(t0 == -1, "R10 held fault no pulse", t0, -1);
    fault_ni[0] = 1'b1;
    measure(0, 700, -1, -1, w, pat, lo, to, ph, t0);
    chk(w == 120, "R10 resume width", w, 120);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_forward();
    t_reverse();
    t_max();
    t_zero();
    t_alternate();
    t_slot();
    t_latch();
    t_fault();
    chk(shoot == 0, "R5 no shoot-through", shoot, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R1-run actual=hang expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule